// File: doc/BRIEF.md
# Byte-Serial Reed-Solomon (255,223) Codeword Encoder

This block turns a stream of information bytes into systematic Reed-Solomon codewords over GF(2^8). Each codeword holds 223 information bytes followed by 32 check bytes, 255 bytes in all. A decoder can correct up to 16 corrupted bytes in such a codeword. Each information byte is accepted over a valid/ready handshake. It is forwarded unchanged to the output one cycle later, and the same byte is folded into a 32-stage polynomial division register.

Once the 223rd byte has been taken, the encoder stops accepting input. It then emits the 32 check bytes on 32 consecutive cycles, and the final one carries a last flag. The field is built on the primitive polynomial x^8+x^4+x^3+x^2+1, and the generator polynomial has the roots alpha^1 through alpha^32, where alpha = 0x02. A start flag sent with an input byte makes that byte the first of a new codeword and drops any partial one. There is no output back-pressure, so the consumer must take one byte per cycle while out_valid is high.

Top module: `rs_codeword_encoder`

## Requirements
- R1: A byte accepted at a clock edge (in_valid and in_ready both high) appears unchanged on out_data, with out_valid high, in the cycle after that edge.
- R2: The cycle after the 223rd information byte is presented, the 32 check bytes follow on consecutive cycles. They are the remainder of m(x)*x^32 divided by the generator, where the first information byte is the highest-degree coefficient of m(x). They are sent highest degree first.
- R3: Every emitted 255-byte codeword evaluates to zero at alpha^k for k = 1..32, in GF(2^8) built on 0x11D with alpha = 0x02.
- R4: out_last is high with the 255th byte of a codeword and at no other time.
- R5: in_ready is low for the whole check-byte phase, and bytes offered then are neither forwarded nor folded into the check bytes.
- R6: A byte accepted with sop high starts a fresh codeword. The check bytes then depend only on the bytes from that one onward.
- R7: After reset, out_valid, out_last and busy are low and in_ready is high.
- R8: busy is high while a codeword is partly received or its check bytes are being emitted. It goes low in the cycle the final check byte is presented.
- R9: During the information phase, a cycle with no accepted byte produces no output. Idle gaps between information bytes do not change the check bytes.
- R10: An all-zero message yields 32 zero check bytes, and the division register is all zero after each codeword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sop | input | 1 | Marks the accompanying byte as first of a new codeword |
| in_data | input | 8 | Information byte |
| in_valid | input | 1 | in_data holds a byte |
| in_ready | output | 1 | Encoder can take a byte this cycle |
| out_data | output | 8 | Codeword byte |
| out_valid | output | 1 | out_data holds a codeword byte |
| out_last | output | 1 | Final byte of a codeword |
| busy | output | 1 | A codeword is in progress |

## Verification
On every cycle the assertions check the following: byte forwarding and its one-cycle latency, the absence of output on idle information cycles, ready being low during the check phase, a continuous check-byte run, out_last only with valid, busy falling together with the last byte, and an empty division register after each codeword. The check-byte values, the zero syndromes at the 32 roots, the position of out_last at byte 255, the effect of a mid-codeword restart and the insensitivity to gaps depend on the whole message. Only the bench scenarios show them, by comparing against a long division and a syndrome evaluation done in the bench.

// File: rtl/rsenc_pkg.sv
package rsenc_pkg;
  localparam int SYM_W    = 8;
  localparam int K_INFO   = 223;
  localparam int N_PAR    = 32;
  localparam int N_TOTAL  = K_INFO + N_PAR;
  localparam logic [SYM_W-1:0] PRIM_LOW = 8'h1D;

  typedef enum logic {PH_DATA, PH_PARITY} phase_t;

  function automatic logic [SYM_W-1:0] gf_xtime(input logic [SYM_W-1:0] a);
    return {a[SYM_W-2:0], 1'b0} ^ (a[SYM_W-1] ? PRIM_LOW : '0);
  endfunction

  function automatic logic [SYM_W-1:0] gf_mul(input logic [SYM_W-1:0] a,
                                               input logic [SYM_W-1:0] b);
    logic [SYM_W-1:0] acc;
    logic [SYM_W-1:0] sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_xtime(sh);
    end
    return acc;
  endfunction

  // coefficient of x^idx in the monic degree-32 generator
  function automatic logic [SYM_W-1:0] gen_coef(input int idx);
    case (idx)
      0:  return 8'd45;   1:  return 8'd216;  2:  return 8'd239;  3:  return 8'd24;
      4:  return 8'd253;  5:  return 8'd104;  6:  return 8'd27;   7:  return 8'd40;
      8:  return 8'd107;  9:  return 8'd50;   10: return 8'd163;  11: return 8'd210;
      12: return 8'd227;  13: return 8'd134;  14: return 8'd224;  15: return 8'd158;
      16: return 8'd119;  17: return 8'd13;   18: return 8'd158;  19: return 8'd1;
      20: return 8'd238;  21: return 8'd164;  22: return 8'd82;   23: return 8'd43;
      24: return 8'd15;   25: return 8'd232;  26: return 8'd246;  27: return 8'd142;
      28: return 8'd50;   29: return 8'd189;  30: return 8'd29;   31: return 8'd232;
      default: return 8'd0;
    endcase
  endfunction
endpackage

// File: rtl/rs_phase_ctrl.sv
module rs_phase_ctrl
  import rsenc_pkg::*;
#(
  parameter int K = K_INFO,
  parameter int P = N_PAR
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic sop,
  output logic in_ready,
  output logic accept,
  output logic restart,
  output logic parity_phase,
  output logic last_par,
  output logic busy
);
  localparam int CW = $clog2(K + 1);
  localparam int PW = (P > 1) ? $clog2(P) : 1;

  phase_t        phase;
  logic [CW-1:0] data_cnt;
  logic [CW-1:0] cur_idx;
  logic [PW-1:0] par_cnt;
  logic          last_data;

  assign parity_phase = (phase == PH_PARITY);
  assign in_ready     = !parity_phase;
  assign accept       = in_valid && in_ready;
  assign restart      = accept && sop;
  assign cur_idx      = restart ? '0 : data_cnt;
  assign last_data    = accept && (cur_idx == CW'(K - 1));
  assign last_par     = parity_phase && (par_cnt == PW'(P - 1));
  assign busy         = parity_phase || (data_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_DATA;
      data_cnt <= '0;
      par_cnt  <= '0;
    end else if (accept) begin
      if (last_data) begin
        data_cnt <= '0;
        phase    <= PH_PARITY;
      end else begin
        data_cnt <= cur_idx + CW'(1);
      end
    end else if (parity_phase) begin
      if (last_par) begin
        par_cnt <= '0;
        phase   <= PH_DATA;
      end else begin
        par_cnt <= par_cnt + PW'(1);
      end
    end
  end
endmodule

// File: rtl/rs_parity_lfsr.sv
module rs_parity_lfsr
  import rsenc_pkg::*;
#(
  parameter int P = N_PAR
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             absorb,
  input  logic             restart,
  input  logic             shift,
  input  logic [SYM_W-1:0] sym_in,
  output logic [SYM_W-1:0] par_out,
  output logic             all_zero
);
  logic [SYM_W-1:0] stage     [P];
  logic [SYM_W-1:0] base      [P];
  logic [SYM_W-1:0] prev_base [P];
  logic [SYM_W-1:0] prev_reg  [P];
  logic [SYM_W-1:0] feedback;

  always_comb begin
    for (int i = 0; i < P; i++) base[i] = restart ? '0 : stage[i];
    prev_base[0] = '0;
    prev_reg[0]  = '0;
    for (int i = 1; i < P; i++) begin
      prev_base[i] = base[i-1];
      prev_reg[i]  = stage[i-1];
    end
  end

  assign feedback = sym_in ^ base[P-1];
  assign par_out  = stage[P-1];

  always_comb begin
    all_zero = 1'b1;
    for (int i = 0; i < P; i++) if (stage[i] != '0) all_zero = 1'b0;
  end

  for (genvar gi = 0; gi < P; gi++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        stage[gi] <= '0;
      else if (shift)
        stage[gi] <= prev_reg[gi];
      else if (absorb)
        stage[gi] <= prev_base[gi] ^ gf_mul(feedback, gen_coef(gi));
    end
  end
endmodule

// File: rtl/rs_codeword_encoder.sv
module rs_codeword_encoder
  import rsenc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sop,
  input  logic [SYM_W-1:0] in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [SYM_W-1:0] out_data,
  output logic             out_valid,
  output logic             out_last,
  output logic             busy
);
  logic             accept;
  logic             restart;
  logic             parity_phase;
  logic             last_par;
  logic             lfsr_zero;
  logic [SYM_W-1:0] par_sym;

  rs_phase_ctrl #(.K(K_INFO), .P(N_PAR)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sop(sop),
    .in_ready(in_ready), .accept(accept), .restart(restart),
    .parity_phase(parity_phase), .last_par(last_par), .busy(busy)
  );

  rs_parity_lfsr #(.P(N_PAR)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .absorb(accept), .restart(restart),
    .shift(parity_phase), .sym_in(in_data), .par_out(par_sym),
    .all_zero(lfsr_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data  <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end else if (accept) begin
      out_data  <= in_data;
      out_valid <= 1'b1;
      out_last  <= 1'b0;
    end else if (parity_phase) begin
      out_data  <= par_sym;
      out_valid <= 1'b1;
      out_last  <= last_par;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end
  end
endmodule

// File: rtl/rs_codeword_encoder_chk.sv
module rs_codeword_encoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] in_data,
  input logic [7:0] out_data,
  input logic       out_valid,
  input logic       out_last,
  input logic       busy,
  input logic       parity_phase,
  input logic       lfsr_zero
);
  p_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));

  p_parity_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    parity_phase |=> out_valid);

  p_last_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  p_ready_parity_r5: assert property (@(posedge clk) disable iff (!rst_n)
    parity_phase |-> !in_ready);

  p_busy_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> out_last);

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!parity_phase && !(in_valid && in_ready)) |=> !out_valid);

  p_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(parity_phase) |-> lfsr_zero);
endmodule

bind rs_codeword_encoder rs_codeword_encoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .out_data(out_data), .out_valid(out_valid),
  .out_last(out_last), .busy(busy), .parity_phase(parity_phase),
  .lfsr_zero(lfsr_zero)
);

// File: tb/rs_codeword_encoder_test.sv
module rs_codeword_encoder_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sop = 1'b0;
  logic [7:0] in_data = 8'd0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] out_data;
  logic       out_valid;
  logic       out_last;
  logic       busy;

  rs_codeword_encoder uut (
    .clk(clk), .rst_n(rst_n), .sop(sop), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .out_data(out_data),
    .out_valid(out_valid), .out_last(out_last), .busy(busy)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  int gexp [256];
  int glog [256];
  int gp   [33];
  int msg  [223];
  int cw   [255];
  int cap  [512];
  int cap_n = 0;
  int last_idx = -1;
  int last_cnt = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n && out_valid) begin
      if (cap_n < 512) cap[cap_n] = int'(out_data);
      if (out_last) begin
        last_idx = cap_n;
        last_cnt++;
      end
      cap_n++;
    end
  end

  initial begin
    wait (cycles > 150000);
    chk(1'b0, "watchdog", cycles, 150000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic int gm(input int a, input int b);
    if (a == 0 || b == 0) return 0;
    return gexp[(glog[a] + glog[b]) % 255];
  endfunction

  task automatic build_field();
    int v = 1;
    for (int i = 0; i < 255; i++) begin
      gexp[i] = v;
      glog[v] = i;
      v = v << 1;
      if (v > 255) v = v ^ 'h11D;
    end
    gexp[255] = 1;
    for (int k = 0; k < 33; k++) gp[k] = 0;
    gp[0] = 1;
    for (int i = 1; i <= 32; i++) begin
      for (int k = 32; k >= 1; k--) gp[k] = gp[k-1] ^ gm(gp[k], gexp[i]);
      gp[0] = gm(gp[0], gexp[i]);
    end
  endtask

  task automatic make_msg(input int mode);
    int x = 12345;
    for (int i = 0; i < 223; i++) begin
      x = x * 1103515245 + 12345;
      case (mode)
        0: msg[i] = 0;
        1: msg[i] = (i + 1) & 255;
        2: msg[i] = (x >>> 16) & 255;
        default: msg[i] = (i * 7 + 3) & 255;
      endcase
    end
    // long division of m(x)*x^32 by the generator
    begin
      int c [255];
      for (int i = 0; i < 255; i++) c[i] = (i < 223) ? msg[i] : 0;
      for (int i = 0; i < 223; i++) begin
        int q = c[i];
        for (int j = 0; j <= 32; j++) c[i+j] = c[i+j] ^ gm(q, gp[32-j]);
      end
      for (int i = 0; i < 255; i++) cw[i] = (i < 223) ? msg[i] : c[i];
    end
  endtask

  task automatic clear_cap();
    cap_n = 0;
    last_idx = -1;
    last_cnt = 0;
  endtask

  task automatic push(input int b, input bit s);
    in_data = 8'(b);
    sop = s;
    in_valid = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
    sop = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic check_cw(input int off, input string tag);
    int bad_d = -1;
    int bad_p = -1;
    int bad_s = 0;
    for (int i = 0; i < 223; i++) if (bad_d < 0 && cap[off+i] != cw[i]) bad_d = i;
    chk(bad_d < 0, {"R1 data ", tag}, bad_d < 0 ? 0 : cap[off+bad_d], bad_d < 0 ? 0 : cw[bad_d]);
    for (int i = 223; i < 255; i++) if (bad_p < 0 && cap[off+i] != cw[i]) bad_p = i;
    chk(bad_p < 0, {"R2 parity ", tag}, bad_p < 0 ? 0 : cap[off+bad_p], bad_p < 0 ? 0 : cw[bad_p]);
    for (int k = 1; k <= 32; k++) begin
      int s = 0;
      for (int n = 0; n < 255; n++) s = gm(s, gexp[k]) ^ cap[off+n];
      if (s != 0 && bad_s == 0) bad_s = k;
    end
    chk(bad_s == 0, {"R3 syndrome root ", tag}, bad_s, 0);
    chk(last_cnt == 1 && last_idx == off + 254, {"R4 last position ", tag}, last_idx, off + 254);
    chk(cap_n == off + 255, {"R9 output count ", tag}, cap_n, off + 255);
    chk(busy == 1'b0, {"R8 busy after ", tag}, int'(busy), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(out_valid == 1'b0, "R7 out_valid", int'(out_valid), 0);
    chk(out_last == 1'b0, "R7 out_last", int'(out_last), 0);
    chk(busy == 1'b0, "R7 busy", int'(busy), 0);
    chk(in_ready == 1'b1, "R7 in_ready", int'(in_ready), 1);
  endtask

  task automatic t_zero();
    make_msg(0);
    clear_cap();
    for (int i = 0; i < 223; i++) push(msg[i], i == 0);
    idle(40);
    check_cw(0, "zero");
    begin
      int nz = 0;
      for (int i = 223; i < 255; i++) if (cap[i] != 0) nz++;
      chk(nz == 0, "R10 zero parity", nz, 0);
    end
  endtask

  task automatic t_ramp();
    make_msg(1);
    clear_cap();
    for (int i = 0; i < 223; i++) begin
      push(msg[i], i == 0);
      if (i == 9) begin
        @(negedge clk);
        chk(busy == 1'b1, "R8 busy mid codeword", int'(busy), 1);
        @(posedge clk); #1;
      end
    end
    idle(40);
    check_cw(0, "ramp");
  endtask

  task automatic t_gaps();
    make_msg(2);
    clear_cap();
    for (int i = 0; i < 223; i++) begin
      push(msg[i], i == 0);
      if (i < 222) idle(i % 3);
    end
    idle(40);
    check_cw(0, "gaps");
  endtask

  task automatic t_ready();
    int low = 0;
    make_msg(1);
    clear_cap();
    for (int i = 0; i < 223; i++) push(msg[i], i == 0);
    in_valid = 1'b1;
    in_data = 8'hEE;
    for (int k = 0; k < 31; k++) begin
      @(negedge clk);
      if (!in_ready && busy) low++;
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    chk(low == 31, "R5 ready low in parity phase", low, 31);
    idle(40);
    check_cw(0, "offered in parity");
  endtask

  task automatic t_restart();
    make_msg(2);
    clear_cap();
    for (int i = 0; i < 100; i++) push(msg[i], i == 0);
    idle(3);
    make_msg(3);
    for (int i = 0; i < 223; i++) push(msg[i], i == 0);
    idle(40);
    check_cw(100, "R6 restart");
  endtask

  initial begin
    build_field();
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_zero();
    t_ramp();
    t_gaps();
    t_ready();
    t_restart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule